// File: doc/BRIEF.md
# Packed SIMD Integer ALU

A purely combinational arithmetic unit that treats its two 32-bit operands as small vectors and processes every element at once. A run-time select splits each operand into four 8-bit lanes or two 16-bit lanes. Lane-wise it adds, takes the minimum or maximum, compares for equality or less-than, rearranges lanes by index, and packs the even lanes of both operands into one word. A multiply-and-sum operation reduces all lanes to one 32-bit scalar.

A broadcast flag replaces every lane of the second operand with that operand's lowest element. This lets one scalar act against a whole vector without a separate splat step. A signedness select governs ordering and the dot-product multiplies. The result settles in the same cycle as the inputs, so the unit fits inside a single execute stage.

Top module: `simd_alu`

## Requirements
- R1: With `opcode`=0 (add), each lane of `result` equals the matching lanes of the operands summed modulo the lane width. `lane_byte`=1 selects four 8-bit lanes and `lane_byte`=0 selects two 16-bit lanes. No carry crosses a lane boundary.
- R2: With `opcode`=1 (min) or 2 (max), each lane gets the smaller or larger operand element. Elements are read as two's complement when `is_signed`=1 and as unsigned otherwise.
- R3: With `opcode`=3 (equal), each lane becomes all ones when the elements match and all zeros when they differ.
- R4: With `opcode`=4 (less-than), each lane becomes all ones when the first operand's element is below the second's, under the `is_signed` reading, and all zeros otherwise.
- R5: With `opcode`=5 (shuffle), destination lane i takes source lane k of `op_a`. In byte mode k is bits [8i+1:8i] of the second operand. In halfword mode k is bit 16i.
- R6: With `opcode`=6 (pack), the result holds the even lanes of `op_a` in its low half and the even lanes of the second operand in its high half, lowest lane first. In byte mode this is {b[23:16], b[7:0], a[23:16], a[7:0]}. In halfword mode it is {b[15:0], a[15:0]}.
- R7: With `opcode`=7 and byte lanes, the result is the sum of the four lane-pair products. The products are signed or unsigned per `is_signed`, and the full 32-bit sum is kept without saturation.
- R8: With `opcode`=7 and halfword lanes, the result is the sum of the two 16×16 products, wrapped modulo 2^32.
- R9: With `repl`=1, every lane of the second operand is replaced by its lowest element (bits [7:0] or [15:0]) for all operations.
- R10: Opcodes 8 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First vector operand |
| op_b | input | 32 | Second vector operand, or shuffle index fields |
| opcode | input | 4 | Operation code (see R1–R10) |
| lane_byte | input | 1 | 1: four 8-bit lanes, 0: two 16-bit lanes |
| is_signed | input | 1 | Two's-complement reading for ordering and products |
| repl | input | 1 | Broadcast the low element of the second operand |
| result | output | 32 | Combinational result |

## Verification
The checks assume that every input is a known value whenever the result is examined. They also assume that the result is read only after the inputs have been stable for a settling interval. The bench changes inputs one nanosecond after a rising edge and samples at the following falling edge, so the unit always has half a period to settle. Random stimulus covers all sixteen opcodes, both lane sizes, both signedness settings and both broadcast settings. Directed vectors add the carry-boundary, extreme-magnitude and wrap-around cases.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_MIN   = 4'd1,
    OP_MAX   = 4'd2,
    OP_CMPEQ = 4'd3,
    OP_CMPLT = 4'd4,
    OP_SHUF  = 4'd5,
    OP_PACK  = 4'd6,
    OP_DOT   = 4'd7
  } simd_op_e;

  // Extend a lane of width w (<=16) to 17 bits, sign- or zero-filled.
  function automatic logic [16:0] widen(input logic [15:0] v, input int w, input logic sgn);
    logic [16:0] r;
    for (int i = 0; i < 17; i++) begin
      r[i] = (i < w) ? v[i] : (sgn & v[w-1]);
    end
    return r;
  endfunction

  function automatic logic lane_lt(input logic [16:0] x, input logic [16:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic [33:0] lane_mul(input logic [16:0] x, input logic [16:0] y);
    logic signed [33:0] p;
    p = $signed(x) * $signed(y);
    return p;
  endfunction

endpackage

// File: rtl/simd_lane_ops.sv
module simd_lane_ops
  import simd_alu_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          sgn_i,
  input  simd_op_e      op_i,
  output logic [LW-1:0] y_o
);
  logic [16:0] a_w, b_w;
  logic        lt, eq;
  logic [LW-1:0] sum;

  assign a_w = widen(16'(a_i), LW, sgn_i);
  assign b_w = widen(16'(b_i), LW, sgn_i);
  assign lt  = lane_lt(a_w, b_w);
  assign eq  = (a_i == b_i);
  assign sum = a_i + b_i;

  always_comb begin
    case (op_i)
      OP_ADD:   y_o = sum;
      OP_MIN:   y_o = lt ? a_i : b_i;
      OP_MAX:   y_o = lt ? b_i : a_i;
      OP_CMPEQ: y_o = {LW{eq}};
      OP_CMPLT: y_o = {LW{lt}};
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_permute.sv
module simd_permute #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              lane_byte_i,
  output logic [DATA_W-1:0] shuf_o,
  output logic [DATA_W-1:0] pack_o
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;
  localparam int IB = $clog2(NB);
  localparam int IH = $clog2(NH);

  logic [DATA_W-1:0] shuf_b, shuf_h, pack_b, pack_h;

  always_comb begin
    shuf_b = '0;
    for (int i = 0; i < NB; i++) begin
      shuf_b[8*i +: 8] = a_i[8*int'(b_i[8*i +: IB]) +: 8];
    end
    shuf_h = '0;
    for (int i = 0; i < NH; i++) begin
      shuf_h[16*i +: 16] = a_i[16*int'(b_i[16*i +: IH]) +: 16];
    end
  end

  always_comb begin
    pack_b = '0;
    for (int j = 0; j < NB/2; j++) begin
      pack_b[8*j +: 8]            = a_i[16*j +: 8];
      pack_b[DATA_W/2 + 8*j +: 8] = b_i[16*j +: 8];
    end
    pack_h = '0;
    for (int j = 0; j < NH/2; j++) begin
      pack_h[16*j +: 16]            = a_i[32*j +: 16];
      pack_h[DATA_W/2 + 16*j +: 16] = b_i[32*j +: 16];
    end
  end

  assign shuf_o = lane_byte_i ? shuf_b : shuf_h;
  assign pack_o = lane_byte_i ? pack_b : pack_h;
endmodule

// File: rtl/simd_dot.sv
module simd_dot
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              lane_byte_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] dot_o
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;

  logic [DATA_W-1:0] acc_b, acc_h;

  always_comb begin
    acc_b = '0;
    for (int i = 0; i < NB; i++) begin
      acc_b = acc_b + DATA_W'(lane_mul(widen(16'(a_i[8*i +: 8]), 8, sgn_i),
                                       widen(16'(b_i[8*i +: 8]), 8, sgn_i)));
    end
    acc_h = '0;
    for (int i = 0; i < NH; i++) begin
      acc_h = acc_h + DATA_W'(lane_mul(widen(a_i[16*i +: 16], 16, sgn_i),
                                       widen(b_i[16*i +: 16], 16, sgn_i)));
    end
  end

  assign dot_o = lane_byte_i ? acc_b : acc_h;
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        opcode,
  input  logic              lane_byte,
  input  logic              is_signed,
  input  logic              repl,
  output logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;

  simd_op_e          op;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] byte_res, half_res, lane_res;
  logic [DATA_W-1:0] shuf_res, pack_res, dot_res;
  logic              op_unused;

  assign op        = simd_op_e'(opcode);
  assign op_unused = opcode[3];
  assign b_eff     = !repl     ? op_b :
                     lane_byte ? {NB{op_b[7:0]}} : {NH{op_b[15:0]}};

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    simd_lane_ops #(.LW(8)) u_lane (
      .a_i(op_a[8*gi +: 8]), .b_i(b_eff[8*gi +: 8]),
      .sgn_i(is_signed), .op_i(op), .y_o(byte_res[8*gi +: 8])
    );
  end

  for (genvar gi = 0; gi < NH; gi++) begin : g_half
    simd_lane_ops #(.LW(16)) u_lane (
      .a_i(op_a[16*gi +: 16]), .b_i(b_eff[16*gi +: 16]),
      .sgn_i(is_signed), .op_i(op), .y_o(half_res[16*gi +: 16])
    );
  end

  assign lane_res = lane_byte ? byte_res : half_res;

  simd_permute #(.DATA_W(DATA_W)) u_perm (
    .a_i(op_a), .b_i(b_eff), .lane_byte_i(lane_byte),
    .shuf_o(shuf_res), .pack_o(pack_res)
  );

  simd_dot #(.DATA_W(DATA_W)) u_dot (
    .a_i(op_a), .b_i(b_eff), .lane_byte_i(lane_byte),
    .sgn_i(is_signed), .dot_o(dot_res)
  );

  always_comb begin
    if (op_unused) begin
      result = '0;
    end else begin
      case (op)
        OP_SHUF: result = shuf_res;
        OP_PACK: result = pack_res;
        OP_DOT:  result = dot_res;
        default: result = lane_res;
      endcase
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [3:0]        opcode,
  input logic              lane_byte,
  input logic              is_signed,
  input logic              repl,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] b_eff
);
  localparam int NB = DATA_W / 8;

  logic mask_ok;
  always_comb begin
    mask_ok = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (result[8*i +: 8] != 8'h00 && result[8*i +: 8] != 8'hFF) mask_ok = 1'b0;
    end
  end

  always_comb begin
    if (opcode == 4'd0 && lane_byte && !repl)
      p_lane_no_carry_r1: assert (result[7:0] == 8'(op_a[7:0] + op_b[7:0]));
    if (opcode == 4'd1 && !lane_byte)
      p_min_picks_operand_r2: assert (result[15:0] == op_a[15:0] || result[15:0] == b_eff[15:0]);
    if ((opcode == 4'd3 || opcode == 4'd4) && lane_byte)
      p_cmp_full_mask_r3: assert (mask_ok);
    if (opcode == 4'd7 && op_a == '0)
      p_dot_zero_operand_r7: assert (result == '0);
    if (opcode == 4'd0 && lane_byte && repl)
      p_bcast_same_delta_r9: assert (8'(result[15:8] - op_a[15:8]) == 8'(result[7:0] - op_a[7:0]));
    if (opcode[3])
      p_unused_zero_r10: assert (result == '0);
  end
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .op_a(op_a), .op_b(op_b), .opcode(opcode), .lane_byte(lane_byte),
  .is_signed(is_signed), .repl(repl), .result(result), .b_eff(b_eff)
);

// File: tb/simd_alu_tb_top.sv
module simd_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  opcode = '0;
  logic        lane_byte = 1'b0, is_signed = 1'b0, repl = 1'b0;
  logic [31:0] result;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  simd_alu dut_i (
    .op_a(op_a), .op_b(op_b), .opcode(opcode), .lane_byte(lane_byte),
    .is_signed(is_signed), .repl(repl), .result(result)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input int op, input bit lb, input bit sg, input bit rp);
    int     w = lb ? 8 : 16;
    int     n = 32 / w;
    longint m = (longint'(1) << w) - 1;
    longint bb = longint'(b);
    longint aa = longint'(a);
    longint r = 0, dot = 0;
    if (op >= 8) return 32'h0;
    if (rp) begin
      bb = 0;
      for (int i = 0; i < n; i++) bb = bb | ((longint'(b) & m) << (i*w));
    end
    if (op == 6) begin
      if (lb) r = (aa & 'hFF) | (((aa >> 16) & 'hFF) << 8) | ((bb & 'hFF) << 16) | (((bb >> 16) & 'hFF) << 24);
      else    r = (aa & 'hFFFF) | ((bb & 'hFFFF) << 16);
      return 32'(r);
    end
    for (int i = 0; i < n; i++) begin
      longint x = (aa >> (i*w)) & m;
      longint y = (bb >> (i*w)) & m;
      longint xs = x, ys = y, lane = 0;
      if (sg && x >= (longint'(1) << (w-1))) xs = x - (longint'(1) << w);
      if (sg && y >= (longint'(1) << (w-1))) ys = y - (longint'(1) << w);
      case (op)
        0: lane = (x + y) & m;
        1: lane = (xs <= ys) ? x : y;
        2: lane = (xs >= ys) ? x : y;
        3: lane = (x == y) ? m : 0;
        4: lane = (xs < ys) ? m : 0;
        5: lane = (aa >> (int'(y & (n-1)) * w)) & m;
        default: dot = dot + xs * ys;
      endcase
      r = r | (lane << (i*w));
    end
    if (op == 7) r = dot;
    return 32'(r);
  endfunction

  function automatic string req_tag(input int op, input bit lb, input bit rp);
    if (op >= 8) return "R10";
    if (rp) return "R9";
    case (op)
      0: return "R1";
      1, 2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return lb ? "R7" : "R8";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input int op,
                       input bit lb, input bit sg, input bit rp);
    logic [31:0] exp;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; opcode = 4'(op); lane_byte = lb; is_signed = sg; repl = rp;
    @(negedge clk);
    exp = model(a, b, op, lb, sg, rp);
    n_tests++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d lb=%0d sg=%0d rp=%0d a=%h b=%h actual=%h expected=%h",
               req_tag(op, lb, rp), op, lb, sg, rp, a, b, result, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // reset state: all-zero inputs give zero (R1)
    @(negedge clk);
    n_tests++;
    if (result !== 32'h0) begin
      n_fail++;
      $display("FAIL R1 reset actual=%h expected=00000000", result);
    end
    rst_n = 1'b1;
    // R1 lane carries stay inside the lane
    apply(32'h80FF7F01, 32'h80010101, 0, 1, 0, 0);
    apply(32'hFFFF0001, 32'h00010001, 0, 0, 0, 0);
    // R2 signed vs unsigned ordering
    apply(32'h80017F80, 32'h01800101, 1, 1, 1, 0);
    apply(32'h80017F80, 32'h01800101, 1, 1, 0, 0);
    apply(32'h8000_0001, 32'h0001_8000, 2, 0, 1, 0);
    apply(32'h8000_0001, 32'h0001_8000, 2, 0, 0, 0);
    // R3 / R4 comparisons
    apply(32'h12345678, 32'h12FF5600, 3, 1, 0, 0);
    apply(32'h12345678, 32'h12345679, 3, 0, 0, 0);
    apply(32'hFF017F00, 32'h01FF8001, 4, 1, 1, 0);
    apply(32'hFF017F00, 32'h01FF8001, 4, 1, 0, 0);
    // R5 shuffle: reversal and halfword swap
    apply(32'hDDCCBBAA, 32'h00010203, 5, 1, 0, 0);
    apply(32'hBBBBAAAA, 32'h00000001, 5, 0, 0, 0);
    // R6 pack even lanes
    apply(32'h44332211, 32'h88776655, 6, 1, 0, 0);
    apply(32'h44332211, 32'h88776655, 6, 0, 0, 0);
    // R7 byte dot extremes
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 7, 1, 0, 0);
    apply(32'h80808080, 32'h80808080, 7, 1, 1, 0);
    apply(32'h7F807F80, 32'h807F807F, 7, 1, 1, 0);
    // R8 halfword dot wrap
    apply(32'h80008000, 32'h80008000, 7, 0, 1, 0);
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 7, 0, 0, 0);
    // R9 broadcast
    apply(32'h01020304, 32'hAABBCC10, 0, 1, 0, 1);
    apply(32'h00050003, 32'h99990004, 1, 0, 0, 1);
    apply(32'h01020304, 32'hFFFFFF02, 7, 1, 0, 1);
    // R10 unused opcodes
    for (int k = 8; k < 16; k++) apply(32'hFFFFFFFF, 32'h12345678, k, 1, 1, 0);
    // random sweep over every opcode and mode
    for (int k = 0; k < 4000; k++) begin
      apply($urandom, $urandom, int'($urandom_range(0, 15)),
            1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule